// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a fully synchronous single-port memory. Every control input and the address are registered on the rising clock edge. Write data follows its address two enabled edges later. A read issued in the cycle after a write therefore uses the data bus in a different cycle from that write. Reads and writes can alternate on every clock with no idle cycle between them.

Read data passes through an output register. The data bus is modelled as a separate input port, an output port and a drive-enable flag; the drive-enable flag takes the place of a tristate pad. A four-beat burst counter advances the two low address bits in either linear or interleaved order. The block also has:

- a clock-enable hold,
- an active-low write enable for each byte lane,
- three chip selects of mixed polarity,
- an asynchronous output enable,
- a sleep input.

The storage array is a parameterized number of 32- or 36-bit words held in registers.

Top module: `ntsram`

## Requirements
- R1: A read load accepted at enabled edge k loads the output register at enabled edge k+1. The word is shown on `dout` with `dout_en` high (when `oe_n` is low) until the next enabled edge, so the host samples it at edge k+2.
- R2: A write accepted at enabled edge k takes its data from `din` at enabled edge k+2. Reads and writes may be issued on consecutive edges in any mix, with no idle cycle.
- R3: Bit i of `lane_we_n` is active low and controls data bits [i*W/4 +: W/4], where lane 0 is the least significant. Lanes whose enable is high keep their stored contents.
- R4: A read accepted one edge after a write to the same address returns the written lanes of that pending write merged with the stored word.
- R5: With `adv` low the address on `addr` is loaded. With `adv` high the previous burst continues in the same direction, and each beat uses its own lane enables. An advance with no active burst issues nothing.
- R6: Burst beat n (n = 1, 2, 3, then 0 on wrap) keeps the upper address bits of the start address. In linear order (`burst_lin` = 1, sampled at the load) the low two bits are (start + n) mod 4. In interleaved order (`burst_lin` = 0) they are start XOR n.
- R7: A load is accepted only when `sel0_n` = 0, `sel1` = 1 and `sel2_n` = 0. Otherwise the cycle is idle and the burst ends, so a following advance issues nothing.
- R8: An edge with `clk_en` low is ignored entirely. The command is not captured, the pipeline, output register and array do not change, and `din` is not sampled.
- R9: `oe_n` high forces `dout_en` low immediately, without a clock edge. It does not affect the pipeline, and taking it low again shows the held read data.
- R10: While `sleep` is high, loads and advances issue no operation and the burst ends. Writes already in flight still take their data from `din`.
- R11: After `rst_n` is taken low, `dout_en` is low, no operation is pending and no burst is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| clk_en | input | 1 | Clock enable; low holds all state |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Standby; blocks new operations |
| adv | input | 1 | 0 = load address, 1 = advance the burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (sampled at a load) |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | 4 | Active-low write enables for the byte lanes |
| din | input | DATA_W | Write data from the bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Read data to the bus |
| dout_en | output | 1 | Bus drive enable |

## Verification
The assertions assume the following about the inputs:

- `rst_n` is pulsed low before the first command.
- `burst_lin` matters only at a load, so a value it takes during an advance is never expected to change the order.
- `oe_n` has no influence on any clocked state. For that reason no assertion watches it, and the bench toggles it only between clock edges.

The bench changes every input on the falling edge, including `clk_en` and `sleep`. Write data is always driven in the cycle that ends on the second enabled edge after its address, which keeps the stimulus inside the protocol the pipeline checks depend on.

// File: rtl/ntsram_pkg.sv
package ntsram_pkg;

   typedef enum logic [1:0] {
      OP_NOP = 2'd0,
      OP_RD  = 2'd1,
      OP_WR  = 2'd2
   } op_e;

   // Low two address bits of a burst beat
   function automatic logic [1:0] beat_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       linear);
      return linear ? 2'(start + beat) : (start ^ beat);
   endfunction

endpackage

// File: rtl/ntsram_seq.sv
module ntsram_seq
   import ntsram_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              sleep,
   input  logic              adv,
   input  logic              rd_wr_n,
   input  logic              burst_lin,
   input  logic [ADDR_W-1:0] addr,
   output op_e               iss_op,
   output logic [ADDR_W-1:0] iss_addr
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ntsram_seq: ADDR_W must be at least 3");
   end

   logic              sel_ok, take;
   logic              b_act, b_lin;
   op_e               b_op;
   logic [ADDR_W-1:0] b_base;
   logic [1:0]        b_cnt, nxt_cnt;

   assign sel_ok  = !sel0_n && sel1 && !sel2_n;
   assign take    = sel_ok && !sleep;
   assign nxt_cnt = 2'(b_cnt + 2'd1);

   always_comb begin
      iss_op   = OP_NOP;
      iss_addr = addr;
      if (!adv) begin
         if (take) iss_op = rd_wr_n ? OP_RD : OP_WR;
      end else begin
         iss_addr = {b_base[ADDR_W-1:2], beat_low(b_base[1:0], nxt_cnt, b_lin)};
         if (b_act && !sleep) iss_op = b_op;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_act  <= 1'b0;
         b_lin  <= 1'b0;
         b_op   <= OP_NOP;
         b_base <= '0;
         b_cnt  <= '0;
      end else if (clk_en) begin
         if (!adv) begin
            b_act  <= take;
            b_lin  <= burst_lin;
            b_op   <= rd_wr_n ? OP_RD : OP_WR;
            b_base <= addr;
            b_cnt  <= '0;
         end else if (sleep) begin
            b_act <= 1'b0;
         end else if (b_act) begin
            b_cnt <= nxt_cnt;
         end
      end
   end

   // R7
   desel_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && (sel0_n || !sel1 || sel2_n)) |-> (iss_op == OP_NOP));

   // R6
   beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && adv && b_act && !sleep) |=> (b_cnt == 2'($past(b_cnt) + 2'd1)));

   // R10
   sleep_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (iss_op == OP_NOP));

endmodule

// File: rtl/ntsram_core.sv
module ntsram_core
   import ntsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  op_e               iss_op,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic [3:0]        lane_we_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_vld
);

   localparam int LANES  = 4;
   localparam int LANE_W = DATA_W / LANES;
   localparam int DEPTH  = 1 << ADDR_W;

   if (DATA_W != 32 && DATA_W != 36) begin : g_bad_width
      $error("ntsram_core: DATA_W must be 32 or 36");
   end

   op_e                           s1_op, s2_op;
   logic [ADDR_W-1:0]             s1_addr, s2_addr;
   logic [LANES-1:0]              s1_be, s2_be;
   logic                          wr_go, hit;
   logic [LANES-1:0][LANE_W-1:0]  rd_lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_op   <= OP_NOP;
         s2_op   <= OP_NOP;
         s1_addr <= '0;
         s2_addr <= '0;
         s1_be   <= '0;
         s2_be   <= '0;
      end else if (clk_en) begin
         s1_op   <= iss_op;
         s1_addr <= iss_addr;
         s1_be   <= ~lane_we_n;
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_be   <= s1_be;
      end
   end

   assign wr_go = clk_en && (s2_op == OP_WR);
   assign hit   = (s2_op == OP_WR) && (s2_addr == s1_addr);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] wd;

      assign wd = din[g*LANE_W +: LANE_W];

      always_ff @(posedge clk) begin
         if (wr_go && s2_be[g]) bank[s2_addr] <= wd;
      end

      assign rd_lane[g] = (hit && s2_be[g]) ? wd : bank[s1_addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rdata  <= '0;
      end else if (clk_en) begin
         rd_vld <= (s1_op == OP_RD);
         if (s1_op == OP_RD) rdata <= rd_lane;
      end
   end

   // R1
   rd_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s1_op == OP_RD) |=> rd_vld);

   // R2
   wr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && s1_op == OP_WR) |=> (s2_op == OP_WR && s2_addr == $past(s1_addr)));

   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> ($stable(rd_vld) && $stable(rdata) && $stable(s1_op) && $stable(s2_op)));

endmodule

// File: rtl/ntsram.sv
module ntsram
   import ntsram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              sleep,
   input  logic              adv,
   input  logic              rd_wr_n,
   input  logic              burst_lin,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        lane_we_n,
   input  logic [DATA_W-1:0] din,
   input  logic              oe_n,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   op_e               iss_op;
   logic [ADDR_W-1:0] iss_addr;
   logic [DATA_W-1:0] rdata;
   logic              rd_vld;

   ntsram_seq #(.ADDR_W(ADDR_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .sel0_n    (sel0_n),
      .sel1      (sel1),
      .sel2_n    (sel2_n),
      .sleep     (sleep),
      .adv       (adv),
      .rd_wr_n   (rd_wr_n),
      .burst_lin (burst_lin),
      .addr      (addr),
      .iss_op    (iss_op),
      .iss_addr  (iss_addr)
   );

   ntsram_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) core_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clk_en    (clk_en),
      .iss_op    (iss_op),
      .iss_addr  (iss_addr),
      .lane_we_n (lane_we_n),
      .din       (din),
      .rdata     (rdata),
      .rd_vld    (rd_vld)
   );

   assign dout    = rdata;
   assign dout_en = rd_vld && !oe_n;

endmodule

// File: tb/ntsram_tb_top.sv
module ntsram_tb_top;

   localparam int AW = 6;
   localparam int DW = 32;
   localparam int LW = DW / 4;
   localparam int NP = 96;

   logic          clk, rst_n, clk_en, sel0_n, sel1, sel2_n, sleep;
   logic          adv, rd_wr_n, burst_lin, oe_n, dout_en;
   logic [AW-1:0] addr;
   logic [3:0]    lane_we_n;
   logic [DW-1:0] din, dout;

   ntsram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel0_n(sel0_n), .sel1(sel1),
      .sel2_n(sel2_n), .sleep(sleep), .adv(adv), .rd_wr_n(rd_wr_n),
      .burst_lin(burst_lin), .addr(addr), .lane_we_n(lane_we_n), .din(din),
      .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   logic [DW-1:0] ref_mem [1<<AW];

   // program table
   logic          p_adv [NP];
   logic          p_rwn [NP];
   logic          p_slp [NP];
   logic          p_lin [NP];
   logic [2:0]    p_cs  [NP];
   logic [AW-1:0] p_addr[NP];
   logic [AW-1:0] p_ea  [NP];
   logic [3:0]    p_ben [NP];
   logic [DW-1:0] p_dat [NP];
   int            p_eff [NP];
   int            np = 0;
   logic          cur_lin = 1'b1;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] baddr(input logic [AW-1:0] b, input int n,
                                           input logic lin);
      logic [1:0] nn;
      nn = 2'(n);
      return {b[AW-1:2], lin ? 2'(b[1:0] + nn) : (b[1:0] ^ nn)};
   endfunction

   function automatic logic [DW-1:0] lanes_put(input logic [DW-1:0] old,
                                               input logic [DW-1:0] nw,
                                               input logic [3:0] ben);
      logic [DW-1:0] r;
      r = old;
      for (int l = 0; l < 4; l++)
         if (!ben[l]) r[l*LW +: LW] = nw[l*LW +: LW];
      return r;
   endfunction

   task automatic add_raw(input logic a_adv, input logic rwn, input logic [2:0] cs,
                          input logic slp, input logic [AW-1:0] a,
                          input logic [3:0] ben, input logic [DW-1:0] d,
                          input int eff, input logic [AW-1:0] ea);
      p_adv[np] = a_adv; p_rwn[np] = rwn; p_cs[np] = cs; p_slp[np] = slp;
      p_lin[np] = cur_lin; p_addr[np] = a; p_ben[np] = ben; p_dat[np] = d;
      p_eff[np] = eff; p_ea[np] = ea;
      np++;
   endtask

   task automatic add_ld(input logic rwn, input logic [AW-1:0] a,
                         input logic [3:0] ben, input logic [DW-1:0] d);
      add_raw(1'b0, rwn, 3'b010, 1'b0, a, ben, d, rwn ? 1 : 2, a);
   endtask

   task automatic add_adv(input logic [3:0] ben, input logic [DW-1:0] d,
                          input int eff, input logic [AW-1:0] ea);
      add_raw(1'b1, 1'b1, 3'b010, 1'b0, '0, ben, d, eff, ea);
   endtask

   task automatic add_nop();
      add_raw(1'b0, 1'b1, 3'b110, 1'b0, '0, 4'hF, '0, 0, '0);
   endtask

   task automatic set_idle();
      adv = 1'b0; rd_wr_n = 1'b1; {sel0_n, sel1, sel2_n} = 3'b110; sleep = 1'b0;
      addr = '0; lane_we_n = 4'hF;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // runs the table; read data checked one edge after issue, write data given two edges after
   task automatic run_prog(input string tag);
      for (int i = 0; i < np + 2; i++) begin
         if (i < np) begin
            adv = p_adv[i]; rd_wr_n = p_rwn[i]; {sel0_n, sel1, sel2_n} = p_cs[i];
            sleep = p_slp[i]; burst_lin = p_lin[i]; addr = p_addr[i];
            lane_we_n = p_ben[i];
         end else begin
            set_idle();
         end
         din = (i >= 2 && p_eff[i-2] == 2) ? p_dat[i-2] : '0;
         step();
         if (i >= 2 && p_eff[i-2] == 2)
            ref_mem[p_ea[i-2]] = lanes_put(ref_mem[p_ea[i-2]], p_dat[i-2], p_ben[i-2]);
         if (i >= 1 && i - 1 < np) begin
            if (p_eff[i-1] == 1)
               chk(dout_en === 1'b1 && dout === ref_mem[p_ea[i-1]], tag, dout,
                   ref_mem[p_ea[i-1]]);
            else
               chk(dout_en === 1'b0, tag, DW'(dout_en), '0);
         end
      end
      np = 0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; clk_en = 1'b1; oe_n = 1'b0; burst_lin = 1'b1; din = '0;
      set_idle();
      repeat (3) @(negedge clk);
      chk(dout_en === 1'b0, "R11 reset drive", DW'(dout_en), '0);
      rst_n = 1'b1;
      step();
      // an advance straight after reset issues nothing
      add_adv(4'h0, '0, 0, '0);
      add_adv(4'h0, '0, 0, '0);
      run_prog("R11 idle after reset");
   endtask

   task automatic t_fill();
      for (int a = 0; a < (1 << AW); a++)
         add_ld(1'b0, AW'(a), 4'h0, DW'(a * 32'h9E3779B1 + 32'h1357));
      run_prog("R2 fill");
      for (int a = 0; a < 8; a++) add_ld(1'b1, AW'(a * 7), 4'h0, '0);
      run_prog("R1 read back");
   endtask

   task automatic t_alt();
      add_ld(1'b0, 6'd1, 4'h0, 32'h1111_0001);
      add_ld(1'b1, 6'd2, 4'h0, '0);
      add_ld(1'b0, 6'd3, 4'h0, 32'h3333_0003);
      add_ld(1'b1, 6'd1, 4'h0, '0);
      add_ld(1'b0, 6'd2, 4'h0, 32'h2222_0002);
      add_ld(1'b1, 6'd3, 4'h0, '0);
      add_ld(1'b1, 6'd2, 4'h0, '0);
      run_prog("R2 alternate");
   endtask

   task automatic t_lanes();
      add_ld(1'b0, 6'd10, 4'b1010, 32'hAABB_CCDD);
      add_nop();
      add_nop();
      add_ld(1'b1, 6'd10, 4'h0, '0);
      add_ld(1'b0, 6'd11, 4'b0111, 32'h9900_0000);
      add_nop();
      add_nop();
      add_ld(1'b1, 6'd11, 4'h0, '0);
      run_prog("R3 lanes");
   endtask

   task automatic t_bypass();
      add_ld(1'b0, 6'd20, 4'h0, 32'hCAFE_F00D);
      add_ld(1'b1, 6'd20, 4'h0, '0);
      add_ld(1'b0, 6'd21, 4'b1100, 32'h0102_0304);
      add_ld(1'b1, 6'd21, 4'h0, '0);
      add_ld(1'b0, 6'd23, 4'b0110, 32'h5A5A_5A5A);
      add_nop();
      add_ld(1'b1, 6'd23, 4'h0, '0);
      add_ld(1'b1, 6'd20, 4'h0, '0);
      run_prog("R4 pending merge");
   endtask

   task automatic t_burst();
      logic [AW-1:0] b0, b1;
      b0 = 6'b001101;
      cur_lin = 1'b1;
      add_ld(1'b0, b0, 4'h0, 32'hB000_0000);
      add_adv(4'h0, 32'hB000_0001, 2, baddr(b0, 1, 1'b1));
      add_adv(4'b1110, 32'hB000_0002, 2, baddr(b0, 2, 1'b1));
      add_adv(4'h0, 32'hB000_0003, 2, baddr(b0, 3, 1'b1));
      add_adv(4'h0, 32'hB000_0004, 2, baddr(b0, 0, 1'b1));
      add_ld(1'b1, b0, 4'h0, '0);
      for (int n = 1; n < 4; n++) add_adv(4'h0, '0, 1, baddr(b0, n, 1'b1));
      run_prog("R5 R6 linear burst");
      b1 = 6'b100110;
      cur_lin = 1'b0;
      add_ld(1'b0, b1, 4'h0, 32'hC000_0000);
      for (int n = 1; n < 4; n++) add_adv(4'h0, DW'(32'hC000_0000 + n), 2, baddr(b1, n, 1'b0));
      add_ld(1'b1, b1, 4'h0, '0);
      for (int n = 1; n < 5; n++) add_adv(4'h0, '0, 1, baddr(b1, n, 1'b0));
      run_prog("R6 interleaved burst");
      cur_lin = 1'b1;
   endtask

   task automatic t_cs();
      add_ld(1'b1, 6'd30, 4'h0, '0);
      add_raw(1'b0, 1'b0, 3'b110, 1'b0, 6'd30, 4'h0, 32'hDEAD_0001, 0, 6'd30);
      add_raw(1'b0, 1'b0, 3'b000, 1'b0, 6'd31, 4'h0, 32'hDEAD_0002, 0, 6'd31);
      add_raw(1'b0, 1'b0, 3'b011, 1'b0, 6'd32, 4'h0, 32'hDEAD_0003, 0, 6'd32);
      add_adv(4'h0, 32'hDEAD_0004, 0, '0);
      add_ld(1'b1, 6'd30, 4'h0, '0);
      add_ld(1'b1, 6'd31, 4'h0, '0);
      add_ld(1'b1, 6'd32, 4'h0, '0);
      run_prog("R7 chip select");
   endtask

   task automatic t_sleep();
      add_ld(1'b0, 6'd40, 4'h0, 32'h5EE9_0040);
      add_raw(1'b0, 1'b1, 3'b010, 1'b1, 6'd41, 4'h0, '0, 0, 6'd41);
      add_raw(1'b1, 1'b1, 3'b010, 1'b1, 6'd0, 4'h0, '0, 0, 6'd0);
      add_adv(4'h0, '0, 0, '0);
      add_ld(1'b1, 6'd40, 4'h0, '0);
      run_prog("R10 sleep");
   endtask

   task automatic t_hold();
      logic [DW-1:0] d;
      d = 32'h7777_0050;
      adv = 1'b0; rd_wr_n = 1'b0; {sel0_n, sel1, sel2_n} = 3'b010; addr = 6'd50;
      lane_we_n = 4'h0; din = '0;
      step();
      clk_en = 1'b0; rd_wr_n = 1'b1; addr = 6'd51; din = 32'hBAD0_BAD0;
      step();
      clk_en = 1'b1; set_idle(); din = 32'hBAD1_BAD1;
      step();
      din = d;
      step();
      ref_mem[50] = d;
      din = '0;
      adv = 1'b0; rd_wr_n = 1'b1; {sel0_n, sel1, sel2_n} = 3'b010; addr = 6'd50;
      step();
      set_idle();
      step();
      chk(dout_en === 1'b1 && dout === d, "R8 write across hold", dout, d);
      clk_en = 1'b0; rd_wr_n = 1'b1; {sel0_n, sel1, sel2_n} = 3'b010; addr = 6'd51;
      step();
      chk(dout_en === 1'b1 && dout === d, "R8 output held", dout, d);
      clk_en = 1'b1; set_idle();
      step();
      chk(dout_en === 1'b0, "R8 held command dropped", DW'(dout_en), '0);
      step();
      chk(dout_en === 1'b0, "R8 no late read", DW'(dout_en), '0);
   endtask

   task automatic t_oe();
      adv = 1'b0; rd_wr_n = 1'b1; {sel0_n, sel1, sel2_n} = 3'b010; addr = 6'd50;
      step();
      set_idle();
      step();
      oe_n = 1'b1;
      #1;
      chk(dout_en === 1'b0, "R9 async off", DW'(dout_en), '0);
      oe_n = 1'b0;
      #1;
      chk(dout_en === 1'b1 && dout === ref_mem[50], "R9 async on", dout, ref_mem[50]);
      step();
      adv = 1'b0; rd_wr_n = 1'b1; {sel0_n, sel1, sel2_n} = 3'b010; addr = 6'd60;
      step();
      set_idle(); oe_n = 1'b1;
      step();
      chk(dout_en === 1'b0, "R9 gated over edge", DW'(dout_en), '0);
      oe_n = 1'b0;
      #1;
      chk(dout_en === 1'b1 && dout === ref_mem[60], "R9 pipeline kept", dout, ref_mem[60]);
      step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_fill();
      t_alt();
      t_lanes();
      t_bypass();
      t_burst();
      t_cs();
      t_sleep();
      t_hold();
      t_oe();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule